// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block owns the status and link state of a processor core across exception entry and handler return. Each cycle it looks at a vector of pending exception causes and at the active-low interrupt pins. It picks one cause by fixed priority. In a single clock edge it then:

- saves the current status word into the target mode's saved-status register,
- writes the return link into that mode's link register,
- rewrites the status word: new mode, interrupt masks, full-width instruction state,
- issues the vector address as the new PC.

For each mode the block also records the return adjustment that belongs to the cause that entered it. A later return strobe therefore reloads the PC as link minus 0, 4 or 8 and restores the status word in the same edge.

The core drives the current PC and an instruction-boundary strobe. It also drives a return strobe, which stands for a flag-setting instruction that writes the PC. Two ordinary write ports let the core update the status word and the active mode's link register outside exception flow.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, cpsr_o reads 0x000000D3: supervisor mode 10011 in bits [4:0], IRQ mask bit 7 set, FIQ mask bit 6 set, compact-instruction bit 5 clear. After reset pc_vld_o is 0, and lr_o and spsr_o read 0.
- R2: On entry, the saved-status register of the target mode receives the complete status word as it stood before entry. This includes flags [31:28], the masks and the mode.
- R3: On entry, bit 5 is cleared and bits [4:0] take the target mode. The target modes are: reset and software interrupt go to 10011, undefined to 11011, both aborts to 10111, IRQ to 10010, FIQ to 10001.
- R4: Every entry sets bit 7. Bit 6 is set only for reset and FIQ entries; other entries keep its previous value.
- R5: On entry, the target mode's link register receives pc_i+4. On the edge after the request, pc_vld_o is 1 for exactly one cycle and pc_o holds the vector. The vectors are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R6: An IRQ is taken only while boundary_i is 1, bit 7 is clear, and either irq_ni is low or exc_req_i[5] is set. FIQ follows the same rule with bit 6, fiq_ni and exc_req_i[6]. A masked or off-boundary interrupt leaves cpsr_o unchanged and pc_vld_o low.
- R7: exc_req_i bit order is 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. When several causes are pending, the winner is chosen in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R8: On a return strobe in a privileged mode, pc_o becomes the active link minus an offset, and cpsr_o becomes that mode's saved status, both on the same edge. The offset is the one recorded when the mode was entered: 0 for undefined, software interrupt and reset, 4 for IRQ, FIQ and prefetch abort, 8 for data abort.
- R9: A return strobe in user mode (10000) loads pc_o with the user link value and leaves cpsr_o unchanged.
- R10: When an entry and a return strobe occur in the same cycle, the entry is performed and the return is dropped.
- R11: Link, saved-status and offset state is kept separately for each mode. A nested entry into another mode and its return leave the outer mode's state intact for that mode's own return.
- R12: psr_we_i loads cpsr_o from psr_i, and lr_we_i loads the active mode's link register from lr_i. An entry in the same cycle overrides both writes, and a return overrides psr_we_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | PC of the current instruction |
| exc_req_i | input | 7 | Pending exception causes, bit order as in R7 |
| irq_ni | input | 1 | Level IRQ pin, active low |
| fiq_ni | input | 1 | Level FIQ pin, active low |
| boundary_i | input | 1 | Instruction boundary; interrupts are sampled only here |
| ret_i | input | 1 | Exception return strobe |
| psr_we_i | input | 1 | Status word write enable |
| psr_i | input | 32 | Status word write data |
| lr_we_i | input | 1 | Active-mode link write enable |
| lr_i | input | PC_W | Link write data |
| pc_vld_o | output | 1 | pc_o carries a new PC this cycle |
| pc_o | output | PC_W | Vector or return PC |
| cpsr_o | output | 32 | Current status word |
| mode_o | output | 5 | Current mode field |
| lr_o | output | PC_W | Link register of the active mode |
| spsr_o | output | 32 | Saved status of the active mode (0 in user mode) |

## Verification
The bench sweeps every cause from several starting status words. Each starting word has the compact-instruction bit set, so a design that forgot to clear that bit, or that set the FIQ mask on an IRQ or abort entry, shows a wrong status word. Every return is checked against its 0/4/8 offset; keying the offset by mode instead of by cause would return data aborts to the wrong instruction. All 127 request combinations are applied and must yield the priority winner's vector. Masked, off-boundary and user-mode-return cases must leave the status word untouched. A nested abort inside an IRQ handler must unwind back to IRQ and then to user, which exposes any sharing of banked state between modes.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned NUM_EXC = 7;
  localparam int unsigned NMODE = 6;
  localparam int unsigned IDX_W = $clog2(NMODE);

  typedef enum logic [2:0] {
    EX_RST  = 3'd0,
    EX_UND  = 3'd1,
    EX_SWI  = 3'd2,
    EX_PABT = 3'd3,
    EX_DABT = 3'd4,
    EX_IRQ  = 3'd5,
    EX_FIQ  = 3'd6
  } exc_e;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  localparam int unsigned PSR_T = 5;
  localparam int unsigned PSR_F = 6;
  localparam int unsigned PSR_I = 7;
  localparam logic [31:0] PSR_RST = 32'h0000_00D3;

  function automatic logic [4:0] exc_mode(exc_e k);
    unique case (k)
      EX_UND:          return MODE_UND;
      EX_PABT, EX_DABT: return MODE_ABT;
      EX_IRQ:          return MODE_IRQ;
      EX_FIQ:          return MODE_FIQ;
      default:         return MODE_SVC;
    endcase
  endfunction

  function automatic logic [4:0] exc_vec(exc_e k);
    unique case (k)
      EX_RST:  return 5'h00;
      EX_UND:  return 5'h04;
      EX_SWI:  return 5'h08;
      EX_PABT: return 5'h0C;
      EX_DABT: return 5'h10;
      EX_IRQ:  return 5'h18;
      default: return 5'h1C;
    endcase
  endfunction

  // bytes to subtract from the link on return
  function automatic logic [3:0] exc_off(exc_e k);
    unique case (k)
      EX_DABT:                return 4'd8;
      EX_PABT, EX_IRQ, EX_FIQ: return 4'd4;
      default:                return 4'd0;
    endcase
  endfunction

  function automatic logic exc_fmask(exc_e k);
    return (k == EX_FIQ) || (k == EX_RST);
  endfunction

  // bank index; index 0 is the user/system bank with no saved status
  function automatic logic [IDX_W-1:0] mode_idx(logic [4:0] m);
    unique case (m)
      MODE_FIQ: return IDX_W'(1);
      MODE_IRQ: return IDX_W'(2);
      MODE_SVC: return IDX_W'(3);
      MODE_ABT: return IDX_W'(4);
      MODE_UND: return IDX_W'(5);
      default:  return IDX_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXC-1:0] exc_req_i,
  input  logic               irq_ni,
  input  logic               fiq_ni,
  input  logic               boundary_i,
  input  logic               i_mask_i,
  input  logic               f_mask_i,
  output logic               take_o,
  output exc_e               kind_o
);
  logic [NUM_EXC-1:0] pend;

  always_comb begin
    pend = exc_req_i;
    pend[EX_IRQ] = boundary_i && !i_mask_i && (exc_req_i[EX_IRQ] || !irq_ni);
    pend[EX_FIQ] = boundary_i && !f_mask_i && (exc_req_i[EX_FIQ] || !fiq_ni);
  end

  always_comb begin
    take_o = |pend;
    if (pend[EX_RST])       kind_o = EX_RST;
    else if (pend[EX_DABT]) kind_o = EX_DABT;
    else if (pend[EX_FIQ])  kind_o = EX_FIQ;
    else if (pend[EX_IRQ])  kind_o = EX_IRQ;
    else if (pend[EX_PABT]) kind_o = EX_PABT;
    else if (pend[EX_UND])  kind_o = EX_UND;
    else                    kind_o = EX_SWI;
  end

  assert_reset_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i[EX_RST] |-> (take_o && kind_o == EX_RST));

  assert_irq_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_mask_i && f_mask_i && exc_req_i[EX_DABT:EX_RST] == '0) |-> !take_o);
endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ent_i,
  input  logic [IDX_W-1:0] ent_idx_i,
  input  logic [PC_W-1:0]  ent_lr_i,
  input  logic [31:0]      ent_spsr_i,
  input  logic [3:0]       ent_off_i,
  input  logic             wr_i,
  input  logic [PC_W-1:0]  wr_lr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  lr_o,
  output logic [31:0]      spsr_o,
  output logic [3:0]       off_o
);
  logic [PC_W-1:0] lr_q   [NMODE];
  logic [31:0]     spsr_q [NMODE];
  logic [3:0]      off_q  [NMODE];

  for (genvar g = 0; g < NMODE; g++) begin : g_bank
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lr_q[g] <= '0;
      else if (ent_i && ent_idx_i == GI) lr_q[g] <= ent_lr_i;
      else if (wr_i && rd_idx_i == GI) lr_q[g] <= wr_lr_i;
    end

    if (g == 0) begin : g_user
      assign spsr_q[g] = '0;
      assign off_q[g]  = '0;
    end else begin : g_priv
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          spsr_q[g] <= '0;
          off_q[g]  <= '0;
        end else if (ent_i && ent_idx_i == GI) begin
          spsr_q[g] <= ent_spsr_i;
          off_q[g]  <= ent_off_i;
        end
      end

      assert_link_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ent_i && ent_idx_i == GI) |=> (lr_q[g] == $past(ent_lr_i)));

      assert_bank_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ent_i && ent_idx_i == GI) |=> $stable(spsr_q[g]));
    end
  end

  always_comb begin
    lr_o = lr_q[0];
    spsr_o = spsr_q[0];
    off_o = off_q[0];
    for (int i = 1; i < NMODE; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        lr_o = lr_q[i];
        spsr_o = spsr_q[i];
        off_o = off_q[i];
      end
    end
  end
endmodule

// File: rtl/exc_psr.sv
module exc_psr
  import exc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ent_i,
  input  exc_e        ent_kind_i,
  input  logic        ret_i,
  input  logic        has_spsr_i,
  input  logic [31:0] spsr_i,
  input  logic        psr_we_i,
  input  logic [31:0] psr_i,
  output logic [31:0] cpsr_o
);
  logic [31:0] cpsr_q, cpsr_d;

  always_comb begin
    cpsr_d = cpsr_q;
    if (ent_i) begin
      cpsr_d[PSR_T] = 1'b0;
      cpsr_d[PSR_I] = 1'b1;
      if (exc_fmask(ent_kind_i)) cpsr_d[PSR_F] = 1'b1;
      cpsr_d[4:0] = exc_mode(ent_kind_i);
    end else if (ret_i && has_spsr_i) begin
      cpsr_d = spsr_i;
    end else if (psr_we_i && !ret_i) begin
      cpsr_d = psr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpsr_q <= PSR_RST;
    else         cpsr_q <= cpsr_d;
  end

  assign cpsr_o = cpsr_q;

  assert_entry_masks_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_i |=> cpsr_q[PSR_I]);

  assert_entry_full_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_i |=> !cpsr_q[PSR_T]);

  assert_fiq_mask_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_i && !exc_fmask(ent_kind_i)) |=> (cpsr_q[PSR_F] == $past(cpsr_q[PSR_F])));

  assert_user_ret_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !ent_i && !has_spsr_i) |=> $stable(cpsr_q));
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [NUM_EXC-1:0] exc_req_i,
  input  logic               irq_ni,
  input  logic               fiq_ni,
  input  logic               boundary_i,
  input  logic               ret_i,
  input  logic               psr_we_i,
  input  logic [31:0]        psr_i,
  input  logic               lr_we_i,
  input  logic [PC_W-1:0]    lr_i,
  output logic               pc_vld_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [31:0]        cpsr_o,
  output logic [4:0]         mode_o,
  output logic [PC_W-1:0]    lr_o,
  output logic [31:0]        spsr_o
);
  localparam int unsigned VEC_W = 5;

  logic             take;
  exc_e             kind;
  logic [31:0]      cpsr;
  logic [IDX_W-1:0] cur_idx;
  logic [PC_W-1:0]  lr_rd;
  logic [31:0]      spsr_rd;
  logic [3:0]       off_rd;
  logic             ret_eff;
  logic             pc_vld_q;
  logic [PC_W-1:0]  pc_q;

  assign cur_idx = mode_idx(cpsr[4:0]);
  assign ret_eff = ret_i && !take;

  exc_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_req_i  (exc_req_i),
    .irq_ni     (irq_ni),
    .fiq_ni     (fiq_ni),
    .boundary_i (boundary_i),
    .i_mask_i   (cpsr[PSR_I]),
    .f_mask_i   (cpsr[PSR_F]),
    .take_o     (take),
    .kind_o     (kind)
  );

  exc_bank #(.PC_W(PC_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ent_i      (take),
    .ent_idx_i  (mode_idx(exc_mode(kind))),
    .ent_lr_i   (pc_i + PC_W'(4)),
    .ent_spsr_i (cpsr),
    .ent_off_i  (exc_off(kind)),
    .wr_i       (lr_we_i && !take),
    .wr_lr_i    (lr_i),
    .rd_idx_i   (cur_idx),
    .lr_o       (lr_rd),
    .spsr_o     (spsr_rd),
    .off_o      (off_rd)
  );

  exc_psr u_psr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ent_i      (take),
    .ent_kind_i (kind),
    .ret_i      (ret_eff),
    .has_spsr_i (cur_idx != '0),
    .spsr_i     (spsr_rd),
    .psr_we_i   (psr_we_i),
    .psr_i      (psr_i),
    .cpsr_o     (cpsr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_vld_q <= 1'b0;
      pc_q     <= '0;
    end else begin
      pc_vld_q <= take || ret_eff;
      if (take)         pc_q <= {{(PC_W-VEC_W){1'b0}}, exc_vec(kind)};
      else if (ret_eff) pc_q <= lr_rd - PC_W'(off_rd);
    end
  end

  assign pc_vld_o = pc_vld_q;
  assign pc_o     = pc_q;
  assign cpsr_o   = cpsr;
  assign mode_o   = cpsr[4:0];
  assign lr_o     = lr_rd;
  assign spsr_o   = spsr_rd;

  assert_pc_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_vld_q |-> $past(take || ret_i));

  assert_entry_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (pc_q < PC_W'(32)) && cpsr[4:0] != MODE_USR);
endmodule

// File: tb/exc_ctrl_test.sv
module exc_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic [6:0]  req = '0;
  logic        irq_n = 1'b1, fiq_n = 1'b1, bnd = 1'b0, ret = 1'b0;
  logic        psr_we = 1'b0, lr_we = 1'b0;
  logic [31:0] psr_d = '0, lr_d = '0;
  logic        pc_vld;
  logic [31:0] pc_o, cpsr, lr, spsr;
  logic [4:0]  mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc_i), .exc_req_i(req),
    .irq_ni(irq_n), .fiq_ni(fiq_n), .boundary_i(bnd), .ret_i(ret),
    .psr_we_i(psr_we), .psr_i(psr_d), .lr_we_i(lr_we), .lr_i(lr_d),
    .pc_vld_o(pc_vld), .pc_o(pc_o), .cpsr_o(cpsr), .mode_o(mode),
    .lr_o(lr), .spsr_o(spsr)
  );

  function automatic logic [4:0] m_mode(int k);
    case (k)
      1: return 5'b11011;
      3, 4: return 5'b10111;
      5: return 5'b10010;
      6: return 5'b10001;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] m_vec(int k);
    case (k)
      0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
      4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
    endcase
  endfunction

  function automatic logic [31:0] m_off(int k);
    if (k == 4) return 8;
    if (k == 3 || k == 5 || k == 6) return 4;
    return 0;
  endfunction

  function automatic int m_prio(logic [6:0] v);
    if (v[0]) return 0;
    if (v[4]) return 4;
    if (v[6]) return 6;
    if (v[5]) return 5;
    if (v[3]) return 3;
    if (v[1]) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] m_entry(logic [31:0] old, int k);
    logic [31:0] r = old;
    r[5] = 1'b0;
    r[7] = 1'b1;
    if (k == 0 || k == 6) r[6] = 1'b1;
    r[4:0] = m_mode(k);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req = '0; irq_n = 1'b1; fiq_n = 1'b1; bnd = 1'b0; ret = 1'b0;
    psr_we = 1'b0; lr_we = 1'b0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic set_psr(logic [31:0] v);
    psr_we = 1'b1; psr_d = v;
    cyc();
  endtask

  task automatic set_lr(logic [31:0] v);
    lr_we = 1'b1; lr_d = v;
    cyc();
  endtask

  task automatic enter(int k, logic [31:0] pc, bit use_pin);
    pc_i = pc;
    bnd = 1'b1;
    if (use_pin && k == 5) irq_n = 1'b0;
    else if (use_pin && k == 6) fiq_n = 1'b0;
    else req[k] = 1'b1;
    cyc();
  endtask

  task automatic do_ret();
    ret = 1'b1;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, s1, pcv;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cpsr", cpsr, 32'h0000_00D3);
    chk("R1 vld", {31'b0, pc_vld}, 0);
    chk("R1 lr", lr, 0);
    chk("R1 spsr", spsr, 0);
    chk("R1 mode", {27'b0, mode}, 32'h13);

    // R2 R3 R4 R5 R8: every cause from several starting words
    for (int k = 0; k < 7; k++) begin
      for (int p = 0; p < 4; p++) begin
        st = {4'((p * 5 + k) & 15), 20'h0, 3'b000, 5'b10000};
        st[5] = 1'b1;
        if (p == 3) st[6] = (k != 6);
        pcv = 32'h1000 + 32'(k * 256 + p * 16);
        set_psr(st);
        enter(k, pcv, p[0]);
        chk($sformatf("R3/R4 cpsr k%0d p%0d", k, p), cpsr, m_entry(st, k));
        chk($sformatf("R2 spsr k%0d", k), spsr, st);
        chk($sformatf("R5 lr k%0d", k), lr, pcv + 4);
        chk($sformatf("R5 vld k%0d", k), {31'b0, pc_vld}, 1);
        chk($sformatf("R5 vec k%0d", k), pc_o, m_vec(k));
        cyc();
        chk($sformatf("R5 vld pulse k%0d", k), {31'b0, pc_vld}, 0);
        do_ret();
        chk($sformatf("R8 ret pc k%0d", k), pc_o, pcv + 4 - m_off(k));
        chk($sformatf("R8 ret cpsr k%0d", k), cpsr, st);
      end
    end

    // R7 priority over all combinations
    st = 32'h0000_0010;
    for (int v = 1; v < 128; v++) begin
      set_psr(st);
      req = 7'(v); bnd = 1'b1;
      cyc();
      chk($sformatf("R7 prio %02h", v), pc_o, m_vec(m_prio(7'(v))));
      chk($sformatf("R7 mode %02h", v), {27'b0, mode}, {27'b0, m_mode(m_prio(7'(v)))});
    end

    // R6 sampling and masking
    st = 32'h6000_0090;
    set_psr(st);
    irq_n = 1'b0; bnd = 1'b1; cyc();
    chk("R6 irq masked cpsr", cpsr, st);
    chk("R6 irq masked vld", {31'b0, pc_vld}, 0);
    req[5] = 1'b1; bnd = 1'b1; cyc();
    chk("R6 irq req masked", cpsr, st);
    st = 32'h6000_0050;
    set_psr(st);
    fiq_n = 1'b0; bnd = 1'b1; cyc();
    chk("R6 fiq masked", cpsr, st);
    irq_n = 1'b0; bnd = 1'b0; cyc();
    chk("R6 off boundary", cpsr, st);
    chk("R6 off boundary vld", {31'b0, pc_vld}, 0);
    irq_n = 1'b0; fiq_n = 1'b0; bnd = 1'b1; cyc();
    chk("R6 irq under fiq mask", pc_o, 32'h18);

    // R9 user-mode return
    st = 32'hA000_0010;
    set_psr(st);
    set_lr(32'h2468);
    do_ret();
    chk("R9 user pc", pc_o, 32'h2468);
    chk("R9 user cpsr", cpsr, st);

    // R10 entry beats return, R12 writes ignored on entry
    req[1] = 1'b1; ret = 1'b1; psr_we = 1'b1; psr_d = 32'hF000_001F;
    lr_we = 1'b1; lr_d = 32'h9999; pc_i = 32'h500;
    cyc();
    chk("R10 vec", pc_o, 32'h04);
    chk("R10 cpsr", cpsr, m_entry(st, 1));
    chk("R12 lr on entry", lr, 32'h504);
    do_ret();
    chk("R10 back", pc_o, 32'h504);
    do_ret();
    chk("R12 user lr kept", pc_o, 32'h2468);
    ret = 1'b1; psr_we = 1'b1; psr_d = 32'h1;
    cyc();
    chk("R12 psr under ret", cpsr, st);
    set_psr(32'h3000_0010);
    chk("R12 psr write", cpsr, 32'h3000_0010);

    // R11 nesting: IRQ then data abort
    st = 32'h3000_0010;
    enter(5, 32'h100, 1);
    s1 = m_entry(st, 5);
    chk("R11 irq cpsr", cpsr, s1);
    enter(4, 32'h200, 0);
    chk("R11 abt spsr", spsr, s1);
    do_ret();
    chk("R11 abt ret pc", pc_o, 32'h1FC);
    chk("R11 abt ret cpsr", cpsr, s1);
    chk("R11 irq lr kept", lr, 32'h104);
    set_lr(32'h3000);
    do_ret();
    chk("R12 handler lr ret", pc_o, 32'h2FFC);
    chk("R11 irq ret cpsr", cpsr, st);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule